// File: doc/BRIEF.md
# Serial Configuration Upload Master

This block runs on the host side of a three-wire configuration link. It takes a write request made of a 4-bit register address and a 12-bit value and sends it to an attached device as one 16-bit serial frame. The address goes first and the value second, and each field goes most significant bit first. The shift clock is divided down from the system clock. After the last bit, a single load pulse tells the device to commit the frame.

Requests use a ready/valid handshake. The block accepts one request, stays busy while it shifts the frame and drives the load pulse, and then raises a one-cycle completion pulse. A request still held valid in that completion cycle is taken at once, so frames can follow each other with no idle gap.

Every line driven onto the link comes straight from a flip-flop. This keeps the lines free of glitches. The divider ratio is derived from the system clock frequency and the maximum permitted shift rate, so the shift clock never exceeds that rate.

Top module: `cfg_upload_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, cfg_sclk, cfg_sdata, cfg_load and xfer_done are low and req_ready is high.
- R2: A request is taken only in a cycle where req_valid and req_ready are both high. req_ready is low from the cycle after acceptance until the completion cycle.
- R3: The frame is {req_addr, req_data}, 16 bits. Bit k of the transfer (k = 0..15) is frame bit 15-k, so the address goes first and each field goes MSB first.
- R4: The shift clock spends HALF_CYC system cycles low and then HALF_CYC cycles high for each bit. HALF_CYC = ceil(CLK_HZ / (2*MAX_SCLK_HZ)), so the shift rate is at most MAX_SCLK_HZ. The defaults give HALF_CYC = 2, which is 12.5 MHz from 50 MHz.
- R5: cfg_sdata changes only together with or while cfg_sclk is low. It is stable in every cycle in which cfg_sclk is high.
- R6: After the sixteenth falling shift-clock edge, cfg_load is high for 2*HALF_CYC cycles, which is one full shift-clock period. During that time cfg_sclk and cfg_sdata are low.
- R7: In the cycle after cfg_load falls, xfer_done is high for exactly one cycle and req_ready is high again.
- R8: When no transfer is in progress, cfg_sclk, cfg_sdata and cfg_load are low.
- R9: req_valid pulses, and changes on req_addr and req_data, while req_ready is low have no effect on the frame being sent.
- R10: A request held valid during the completion cycle is accepted at the end of that cycle. Its first low shift-clock phase begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 4 | Register address of the request |
| req_data | input | 12 | Register value of the request |
| xfer_done | output | 1 | One-cycle pulse when the load pulse has ended |
| cfg_sclk | output | 1 | Divided shift clock, idles low |
| cfg_sdata | output | 1 | Serial frame data |
| cfg_load | output | 1 | Load strobe that commits the frame |

## Verification
The assertions check the following on every cycle:
- serial data stays still while the shift clock is high;
- each high phase of the shift clock lasts HALF_CYC cycles;
- the load pulse always comes with a low clock and low data;
- the completion pulse follows the falling edge of the load pulse, is one cycle wide and brings ready back;
- the link lines are quiet whenever the block is ready.

Some behaviour cannot be checked by a property and needs the bench's scenarios: that the bits arrive in address-first, MSB-first order for particular values, that requests made while busy are ignored, and that a held request is taken back-to-back. The bench's per-cycle reference model covers these.

// File: rtl/cfg_upload_pkg.sv
package cfg_upload_pkg;

    typedef enum logic [1:0] {
        UPL_IDLE  = 2'd0,
        UPL_SHIFT = 2'd1,
        UPL_LOAD  = 2'd2
    } upl_state_e;

    // Rounded-up integer division, used to keep the shift rate under its cap
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/upl_phase_timer.sv
// Counts system cycles within a shift-clock half period, or within a full
// period while the load strobe is held.
module upl_phase_timer #(
    parameter int HALF_CYC = 2,
    localparam int CNT_W   = (2 * HALF_CYC > 1) ? $clog2(2 * HALF_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic full_period,
    output logic expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit  = full_period ? CNT_W'(2 * HALF_CYC - 1) : CNT_W'(HALF_CYC - 1);
        expire = run && (cnt_q == limit);
        cnt_d  = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/upl_frame_shifter.sv
// Parallel-load, shift-left register. Its top bit drives the serial line
// directly, and zeros are shifted in behind the frame.
module upl_frame_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift_en,
    output logic               msb
);
    logic [FRAME_W-1:0] sreg_d, sreg_q;

    always_comb begin
        sreg_d = sreg_q;
        if (load_en) begin
            sreg_d = frame_in;
        end else if (shift_en) begin
            sreg_d = {sreg_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else begin
            sreg_q <= sreg_d;
        end
    end

    assign msb = sreg_q[FRAME_W-1];
endmodule

// File: rtl/cfg_upload_master.sv
module cfg_upload_master #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 12,
    parameter int CLK_HZ      = 50_000_000,
    parameter int MAX_SCLK_HZ = 20_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              xfer_done,
    output logic              cfg_sclk,
    output logic              cfg_sdata,
    output logic              cfg_load
);
    import cfg_upload_pkg::*;

    localparam int FRAME_W  = ADDR_W + DATA_W;
    localparam int BIT_W    = $clog2(FRAME_W);
    localparam int HALF_RAW = ceil_div(CLK_HZ, 2 * MAX_SCLK_HZ);
    localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

    typedef struct packed {
        upl_state_e       state;
        logic [BIT_W-1:0] bitcnt;
        logic             sclk;
        logic             load;
        logic             ready;
        logic             done;
    } upl_regs_t;

    upl_regs_t r_d, r_q;
    logic      accept;
    logic      shift_now;
    logic      tmr_expire;
    logic      tmr_run;
    logic      tmr_full;

    assign tmr_run  = (r_q.state != UPL_IDLE);
    assign tmr_full = (r_q.state == UPL_LOAD);

    upl_phase_timer #(
        .HALF_CYC(HALF_CYC)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tmr_run),
        .full_period(tmr_full),
        .expire     (tmr_expire)
    );

    upl_frame_shifter #(
        .FRAME_W(FRAME_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (accept),
        .frame_in({req_addr, req_data}),
        .shift_en(shift_now),
        .msb     (cfg_sdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        accept    = 1'b0;
        shift_now = 1'b0;
        unique case (r_q.state)
            UPL_IDLE: begin
                if (req_valid && r_q.ready) begin
                    accept     = 1'b1;
                    r_d.state  = UPL_SHIFT;
                    r_d.ready  = 1'b0;
                    r_d.sclk   = 1'b0;
                    r_d.bitcnt = '0;
                end
            end
            UPL_SHIFT: begin
                if (tmr_expire) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                    end else begin
                        r_d.sclk  = 1'b0;
                        shift_now = 1'b1;
                        if (r_q.bitcnt == BIT_W'(FRAME_W - 1)) begin
                            r_d.state = UPL_LOAD;
                            r_d.load  = 1'b1;
                        end else begin
                            r_d.bitcnt = r_q.bitcnt + BIT_W'(1);
                        end
                    end
                end
            end
            UPL_LOAD: begin
                if (tmr_expire) begin
                    r_d.load  = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.ready = 1'b1;
                    r_d.state = UPL_IDLE;
                end
            end
            default: begin
                r_d.state = UPL_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= UPL_IDLE;
            r_q.bitcnt <= '0;
            r_q.sclk   <= 1'b0;
            r_q.load   <= 1'b0;
            r_q.ready  <= 1'b1;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.ready;
    assign xfer_done = r_q.done;
    assign cfg_sclk  = r_q.sclk;
    assign cfg_load  = r_q.load;
endmodule

// File: rtl/cfg_upload_chk.sv
module cfg_upload_chk #(
    parameter int HALF_CYC = 2,
    localparam int CW      = $clog2(2 * HALF_CYC + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic xfer_done,
    input logic cfg_sclk,
    input logic cfg_sdata,
    input logic cfg_load
);
    logic [CW-1:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (cfg_sclk) begin
            hi_run_q <= hi_run_q + CW'(1);
        end else begin
            hi_run_q <= '0;
        end
    end

    // R5
    sdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sclk |-> $stable(cfg_sdata));

    // R4
    sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_sclk) |-> (hi_run_q == CW'(HALF_CYC)));

    // R6
    load_quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (!cfg_sclk && !cfg_sdata));

    // R7
    done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_load) |-> (xfer_done && req_ready));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cfg_sclk && !cfg_sdata && !cfg_load));
endmodule

bind cfg_upload_master cfg_upload_chk #(
    .HALF_CYC(HALF_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .xfer_done(xfer_done),
    .cfg_sclk (cfg_sclk),
    .cfg_sdata(cfg_sdata),
    .cfg_load (cfg_load)
);

// File: tb/cfg_upload_master_tb_top.sv
module cfg_upload_master_tb_top;
    localparam int CLK_HZ = 50_000_000;
    localparam int MAX_HZ = 20_000_000;
    localparam int HALF   = (CLK_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);
    // expected vector: {ready, done, load, sclk, sdata}
    localparam logic [4:0] IDLE_V = 5'b10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [11:0] req_data = '0;
    logic        req_ready, xfer_done, cfg_sclk, cfg_sdata, cfg_load;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [4:0] cur = IDLE_V;
    logic [4:0] exp_q[$];
    logic       prev_sdata = 1'b0;
    logic       prev_sclk = 1'b0;

    always #10 clk = ~clk;

    cfg_upload_master dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_data (req_data),
        .xfer_done(xfer_done),
        .cfg_sclk (cfg_sclk),
        .cfg_sdata(cfg_sdata),
        .cfg_load (cfg_load)
    );

    task automatic push_frame(input logic [15:0] fr);
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < HALF; c++) exp_q.push_back({4'b0000, fr[15-k]});
            for (int c = 0; c < HALF; c++) exp_q.push_back({4'b0001, fr[15-k]});
        end
        for (int c = 0; c < 2 * HALF; c++) exp_q.push_back(5'b00100);
        exp_q.push_back(5'b11000);
    endtask

    // Reference model: advances on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q.delete();
            cur = IDLE_V;
        end else begin
            if (cur[4] && req_valid) push_frame({req_addr, req_data});
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else cur = IDLE_V;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0] act;
            act = {req_ready, xfer_done, cfg_load, cfg_sclk, cfg_sdata};
            checks++;
            if (act !== cur) begin
                failures++;
                if (cur == IDLE_V)   $display("FAIL R8 idle lines: actual=%b expected=%b", act, cur);
                else if (cur[3])     $display("FAIL R7 completion: actual=%b expected=%b", act, cur);
                else if (cur[2])     $display("FAIL R6 load strobe: actual=%b expected=%b", act, cur);
                else if (act[4])     $display("FAIL R2 ready while busy: actual=%b expected=%b", act, cur);
                else if (act[1] != cur[1]) $display("FAIL R4 shift clock: actual=%b expected=%b", act, cur);
                else                 $display("FAIL R3 frame bit: actual=%b expected=%b", act, cur);
            end
            if (cfg_sclk && prev_sclk) begin
                checks++;
                if (cfg_sdata !== prev_sdata) begin
                    failures++;
                    $display("FAIL R5 data moved with clock high: actual=%b expected=%b", cfg_sdata, prev_sdata);
                end
            end
            prev_sdata = cfg_sdata;
            prev_sclk  = cfg_sclk;
        end
    end

    task automatic send(input logic [3:0] a, input logic [11:0] d, input bit keep);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(req_ready && exp_q.size() == 0 && !req_valid));
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                failures++;
                $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset values, during reset
        repeat (3) @(negedge clk);
        checks++;
        if ({req_ready, xfer_done, cfg_load, cfg_sclk, cfg_sdata} !== IDLE_V) begin
            failures++;
            $display("FAIL R1 reset state: actual=%b expected=%b",
                     {req_ready, xfer_done, cfg_load, cfg_sclk, cfg_sdata}, IDLE_V);
        end
        rst_n = 1'b1;

        // R3/R4/R6/R7: mixed bit pattern
        send(4'hA, 12'h5C3, 1'b0);
        wait_idle();
        // R3: all-zero and all-one frames
        send(4'h0, 12'h000, 1'b0);
        wait_idle();
        send(4'hF, 12'hFFF, 1'b0);
        wait_idle();
        // R3: single set bits at the field boundaries
        send(4'h1, 12'h800, 1'b0);
        wait_idle();

        // R9: valid pulses and new data while busy must be ignored
        send(4'h6, 12'h0A5, 1'b0);
        repeat (10) @(negedge clk);
        req_valid = 1'b1; req_addr = 4'h9; req_data = 12'hF0F;
        repeat (5) @(negedge clk);
        req_valid = 1'b0; req_addr = 4'h3;
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_data = 12'h123;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // R10: back-to-back frames with valid held through completion
        send(4'h5, 12'hA5A, 1'b1);
        send(4'hC, 12'h3C3, 1'b1);
        send(4'h2, 12'h001, 1'b0);
        wait_idle();

        finish_run();
    end
endmodule